// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block sits between the request queue of a processor core and an external memory bus. It takes one access request at a time through a valid/ready handshake and turns it into a series of bus cycles. Each cycle is marked nonsequential (the first cycle of an access) or sequential (each cycle after it). The supported requests are a single read or write, a multiple read or write, the drain of one buffered write, and a cache linefetch.

Every bus output is registered. A cycle stays on the bus until the memory wait input is low at a clock edge. When the last cycle of an access completes and no new request is waiting, the bus goes idle: the cycle-valid flag drops, and the address, direction, size and cycle-type outputs keep the values they had, so the bus lines do not toggle. A new request can be accepted during the final cycle of the current one, so back-to-back accesses leave no gap on the bus.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, bus_active_o and done_o are 0 and req_ready_o is 1.
- R2: While bus_active_o is 0, bus_addr_o, bus_write_o and bus_byte_o keep the values of the last cycle driven.
- R3: The first cycle of every request has bus_seq_o = 0. Every later cycle of the same request has bus_seq_o = 1.
- R4: req_kind_i encodes the request: 0 single, 1 multiple, 2 buffered write, 3 linefetch. A single request and a buffered-write request each give exactly one cycle. A multiple request gives req_beats_i cycles, where 0 counts as 1 and values above 16 count as 16.
- R5: Each cycle after the first in a multiple request advances the address by 4 for word accesses (bus_byte_o = 0) and by 1 for byte accesses.
- R6: For single, multiple and buffered-write requests, bus_write_o and bus_byte_o equal req_write_i and req_byte_i captured when the request was accepted.
- R7: Buffered writes issued back to back each start with a nonsequential cycle, even when their addresses are contiguous.
- R8: A linefetch gives exactly four cycles. The first address is the request address with bits [3:0] cleared, and each later cycle adds 4.
- R9: Every linefetch cycle is a word read (bus_write_o = 0, bus_byte_o = 0), whatever req_write_i and req_byte_i say.
- R10: While mem_wait_i is high during an active cycle, that cycle and all bus outputs stay unchanged at the next edge.
- R11: req_ready_o is high exactly when the bus is idle, or when the current cycle is the last of its request and mem_wait_i is low. A request accepted then drives its first cycle in the very next clock cycle.
- R12: done_o is high exactly while the final cycle of a request is on the bus with mem_wait_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted at this edge if valid |
| req_kind_i | input | 2 | Request type (see R4) |
| req_addr_i | input | AW | Start address |
| req_write_i | input | 1 | 1 = write |
| req_byte_i | input | 1 | 1 = byte access |
| req_beats_i | input | CW | Beat count for multiple requests |
| mem_wait_i | input | 1 | Memory stalls the current cycle |
| bus_active_o | output | 1 | A bus cycle is in progress |
| bus_addr_o | output | AW | Cycle address |
| bus_write_o | output | 1 | Cycle direction |
| bus_byte_o | output | 1 | Cycle size |
| bus_seq_o | output | 1 | 1 = sequential cycle |
| done_o | output | 1 | Final cycle of a request is completing |

## Verification
The hardest case to reach from the ports is a new request that arrives while the last cycle of the previous one is still stalled. The request must wait while mem_wait_i is high and then be taken in the same edge that completes the old cycle. This matters most between buffered writes to contiguous addresses, where merging them into one burst would look like a plausible optimisation. The stimulus offers requests back to back while a pseudo-random wait pattern runs, so acceptance falls on stalled and unstalled final cycles alike. A behavioural model in the bench checks every output on every cycle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_MULTI  = 2'd1,
    KIND_BUFWR  = 2'd2,
    KIND_LINE   = 2'd3
  } req_kind_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LINE_BEATS = 4;
  localparam int unsigned LINE_OFS   = $clog2(WORD_BYTES * LINE_BEATS);
endpackage

// File: rtl/bus_seq_decode.sv
module bus_seq_decode
  import bus_seq_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned MAX_BEATS = 16,
  localparam int unsigned CW       = $clog2(MAX_BEATS + 1)
) (
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic          byte_i,
  input  logic [CW-1:0] beats_i,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic          byte_o,
  output logic [CW-1:0] cnt_o,
  output logic [2:0]    step_o
);
  localparam logic [CW-1:0] BEATS_MAX = CW'(MAX_BEATS);
  localparam logic [CW-1:0] BEATS_ONE = CW'(1);
  localparam logic [CW-1:0] BEATS_LINE = CW'(LINE_BEATS);

  logic [CW-1:0] clamped;

  always_comb begin
    if (beats_i == '0)           clamped = BEATS_ONE;
    else if (beats_i > BEATS_MAX) clamped = BEATS_MAX;
    else                          clamped = beats_i;
  end

  always_comb begin
    addr_o  = addr_i;
    write_o = write_i;
    byte_o  = byte_i;
    cnt_o   = BEATS_ONE;
    step_o  = 3'(WORD_BYTES);
    unique case (req_kind_e'(kind_i))
      KIND_MULTI: begin
        cnt_o  = clamped;
        step_o = byte_i ? 3'd1 : 3'(WORD_BYTES);
      end
      KIND_LINE: begin
        addr_o  = {addr_i[AW-1:LINE_OFS], {LINE_OFS{1'b0}}};
        write_o = 1'b0;
        byte_o  = 1'b0;
        cnt_o   = BEATS_LINE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_seq_engine.sv
module bus_seq_engine #(
  parameter int unsigned AW        = 32,
  parameter int unsigned MAX_BEATS = 16,
  localparam int unsigned CW       = $clog2(MAX_BEATS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_write_i,
  input  logic          ld_byte_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic [2:0]    ld_step_i,
  input  logic          wait_i,
  output logic          active_o,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic          byte_o,
  output logic          seq_o,
  output logic          last_o
);
  logic          active_q, write_q, byte_q, seq_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [2:0]    step_q;
  logic          advance, last;

  assign last    = (left_q == CW'(1));
  assign advance = active_q && !wait_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      write_q  <= 1'b0;
      byte_q   <= 1'b0;
      seq_q    <= 1'b0;
      left_q   <= '0;
      step_q   <= '0;
    end else if (advance && !last) begin
      left_q <= left_q - CW'(1);
      addr_q <= addr_q + AW'(step_q);
      seq_q  <= 1'b1;
    end else if (!active_q || advance) begin
      if (load_i) begin
        active_q <= 1'b1;
        addr_q   <= ld_addr_i;
        write_q  <= ld_write_i;
        byte_q   <= ld_byte_i;
        seq_q    <= 1'b0;
        left_q   <= ld_cnt_i;
        step_q   <= ld_step_i;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign addr_o   = addr_q;
  assign write_o  = write_q;
  assign byte_o   = byte_q;
  assign seq_o    = seq_q;
  assign last_o   = active_q && last;

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !load_i) |=> ($stable(addr_q) && $stable(write_q) && $stable(byte_q)));

  a_r10_wait_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && wait_i) |=> (active_q && $stable(addr_q) && $stable(seq_q) && $stable(write_q)));

  a_r3_first_nonseq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (active_q && !seq_q));

  a_r5_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !last) |=> (active_q && seq_q && addr_q == $past(addr_q) + AW'($past(step_q))));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned MAX_BEATS = 16,
  localparam int unsigned CW       = $clog2(MAX_BEATS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_kind_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  input  logic          req_byte_i,
  input  logic [CW-1:0] req_beats_i,
  input  logic          mem_wait_i,
  output logic          bus_active_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  output logic          bus_byte_o,
  output logic          bus_seq_o,
  output logic          done_o
);
  logic [AW-1:0] d_addr;
  logic          d_write, d_byte, last, load;
  logic [CW-1:0] d_cnt;
  logic [2:0]    d_step;

  bus_seq_decode #(.AW(AW), .MAX_BEATS(MAX_BEATS)) u_decode (
    .kind_i (req_kind_i),
    .addr_i (req_addr_i),
    .write_i(req_write_i),
    .byte_i (req_byte_i),
    .beats_i(req_beats_i),
    .addr_o (d_addr),
    .write_o(d_write),
    .byte_o (d_byte),
    .cnt_o  (d_cnt),
    .step_o (d_step)
  );

  assign req_ready_o = !bus_active_o || (last && !mem_wait_i);
  assign load        = req_valid_i && req_ready_o;
  assign done_o      = last && !mem_wait_i;

  bus_seq_engine #(.AW(AW), .MAX_BEATS(MAX_BEATS)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .ld_addr_i (d_addr),
    .ld_write_i(d_write),
    .ld_byte_i (d_byte),
    .ld_cnt_i  (d_cnt),
    .ld_step_i (d_step),
    .wait_i    (mem_wait_i),
    .active_o  (bus_active_o),
    .addr_o    (bus_addr_o),
    .write_o   (bus_write_o),
    .byte_o    (bus_byte_o),
    .seq_o     (bus_seq_o),
    .last_o    (last)
  );

  a_r8_line_aligned_word_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && req_kind_i == 2'(KIND_LINE)) |=>
      (bus_addr_o[LINE_OFS-1:0] == '0 && !bus_byte_o && !bus_write_o));
endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
  localparam int AW = 32;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_kind_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_write_i = 1'b0, req_byte_i = 1'b0;
  logic [CW-1:0] req_beats_i = '0;
  logic          mem_wait_i = 1'b0;
  logic          req_ready_o, bus_active_o, bus_write_o, bus_byte_o, bus_seq_o, done_o;
  logic [AW-1:0] bus_addr_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit wait_en = 0;
  logic [7:0] lfsr = 8'h5a;

  always #2 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_kind_i(req_kind_i), .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .req_byte_i(req_byte_i), .req_beats_i(req_beats_i), .mem_wait_i(mem_wait_i),
    .bus_active_o(bus_active_o), .bus_addr_o(bus_addr_o), .bus_write_o(bus_write_o),
    .bus_byte_o(bus_byte_o), .bus_seq_o(bus_seq_o), .done_o(done_o)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit       m_active = 0, m_write = 0, m_byte = 0, m_seq = 0;
  logic [31:0] m_addr = '0;
  int       m_left = 0, m_step = 4, m_kind = 0;

  function automatic bit exp_ready();
    return !m_active || (m_left == 1 && !mem_wait_i);
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_active = 0; m_write = 0; m_byte = 0; m_seq = 0; m_addr = '0; m_left = 0;
    end else begin
      bit fin, acc;
      fin = m_active && !mem_wait_i;
      acc = req_valid_i && exp_ready();
      if (fin && m_left > 1) begin
        m_left--; m_addr = m_addr + m_step; m_seq = 1;
      end else if (fin || !m_active) begin
        if (acc) begin
          int b;
          m_active = 1; m_seq = 0; m_kind = req_kind_i;
          m_addr = req_addr_i; m_write = req_write_i; m_byte = req_byte_i;
          m_left = 1; m_step = 4;
          b = req_beats_i;
          if (b == 0) b = 1;
          if (b > 16) b = 16;
          case (req_kind_i)
            2'd1: begin m_left = b; m_step = req_byte_i ? 1 : 4; end
            2'd3: begin m_addr = {req_addr_i[31:4], 4'h0}; m_write = 0; m_byte = 0; m_left = 4; end
            default: ;
          endcase
        end else m_active = 0;
      end
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_wait_i <= wait_en ? (lfsr[0] & lfsr[2]) : 1'b0;
  end

  bit pv_stall = 0;
  logic [31:0] pv_addr = '0;
  always @(negedge clk) begin
    #1;
    if (rst_ni && !finished) begin
      string t_addr, t_seq, t_flag;
      t_addr = !m_active ? "R2" : (m_kind == 3 ? "R8" : (m_seq ? "R5" : "R4"));
      t_seq  = m_kind == 2 ? "R7" : "R3";
      t_flag = !m_active ? "R2" : (m_kind == 3 ? "R9" : "R6");
      check("R4", "bus_active_o", bus_active_o, m_active);
      check(t_addr, "bus_addr_o", bus_addr_o, m_addr);
      check(t_flag, "bus_write_o", bus_write_o, m_write);
      check(t_flag, "bus_byte_o", bus_byte_o, m_byte);
      if (m_active) check(t_seq, "bus_seq_o", bus_seq_o, m_seq);
      check("R11", "req_ready_o", req_ready_o, exp_ready());
      check("R12", "done_o", done_o, m_active && m_left == 1 && !mem_wait_i);
      if (pv_stall) check("R10", "stalled addr", bus_addr_o, pv_addr);
      pv_stall = bus_active_o && mem_wait_i;
      pv_addr  = bus_addr_o;
    end
  end

  task automatic send(int kind, logic [31:0] a, bit w, bit b, int beats);
    bit acc = 0;
    req_valid_i = 1; req_kind_i = 2'(kind); req_addr_i = a;
    req_write_i = w; req_byte_i = b; req_beats_i = CW'(beats);
    while (!acc) begin
      #1 acc = req_ready_o;
      @(negedge clk);
    end
    req_valid_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    check("R1", "reset active", bus_active_o, 0);
    check("R1", "reset ready", req_ready_o, 1);
    check("R1", "reset done", done_o, 0);
    @(negedge clk);
    // no wait: basic patterns
    send(0, 32'h0000_1000, 0, 0, 1);
    idle(3);
    send(0, 32'h0000_2003, 1, 1, 1);
    idle(2);
    send(1, 32'h0000_3000, 0, 0, 4);
    send(1, 32'h0000_4001, 1, 1, 3);
    idle(2);
    send(2, 32'h0000_5000, 1, 0, 1);
    send(2, 32'h0000_5004, 1, 0, 1);
    send(2, 32'h0000_5008, 1, 1, 1);
    idle(2);
    send(3, 32'h0000_1237, 1, 1, 9);
    idle(3);
    send(1, 32'h0000_6000, 0, 0, 16);
    send(1, 32'h0000_7000, 0, 0, 0);
    send(1, 32'h0000_8000, 1, 0, 25);
    idle(2);
    // with memory wait
    wait_en = 1;
    for (int i = 0; i < 40; i++) begin
      send(i % 4, 32'h0001_0000 + 32'(i * 52 + i % 3), i[0], i[1], i % 7 + 1);
      if (i % 5 == 0) idle(3);
    end
    idle(30);
    wait_en = 0;
    idle(4);
    finish_run();
  end
endmodule